// File: doc/BRIEF.md
# Microcoded Bus Waveform Generator

This block produces the control strobes of an external memory bus by replaying words from a small pattern RAM that software fills in advance. The block runs on a clock four times faster than the bus clock. Each pattern word therefore covers one bus cycle, which is split into four quarter phases, T1 to T4. In each phase the word gives one level for the chip-select strobe and one level for the byte-select strobe. The word also gives six general-purpose line levels that hold for the whole bus cycle. A word can mark itself as the last one of its sequence.

Software writes the pattern RAM through a pointer-based port. It loads a write pointer, then pushes words. The pointer steps forward after every write, and software can read it back to confirm that its writes were taken. An access request carries four things: a start index into the RAM, a bank-hit vector, the port size of the bank and the two low address bits. The chip-select pattern reaches only the banks flagged in the hit vector. The byte-select pattern reaches only the byte lanes that the access touches.

The controller has two states. SEQ_IDLE moves to SEQ_RUN when a request arrives (transition *launch*). SEQ_RUN returns to SEQ_IDLE at the end of phase T4 in two cases: when the current word carries the last flag (transition *finish*), or when the current word is at the top index without that flag (transition *overrun*). The *overrun* transition raises a one-cycle error pulse.

Top module: `busseq_wavegen`

## Requirements
- R1: After reset, and whenever no sequence runs, every `cs_n` and `bs_n` bit is 1, `gpl` is 0 and `busy` is 0. `err_wrap` is 0 except for its pulse under R9.
- R2: `cfg_ptr_load` sets the write pointer to `cfg_ptr_val`. When `cfg_ptr_load` is low, a `cfg_we` pulse stores `cfg_wdata` at the pointer and then adds 1 to the pointer, so that index DEPTH-1 steps to 0. The pointer appears on `cfg_ptr`.
- R3: A request taken in SEQ_IDLE raises `busy` on the next cycle. The block then plays the word at `req_start` for 4 clock cycles, followed by the following indices in order, 4 clock cycles each.
- R4: In phase Tk (k = 1..4), the chip-select level is word bit 32-k (bits 31..28) and the byte-select level is word bit 28-k (bits 27..24). A level of 0 drives the active-low output low.
- R5: During a sequence, `cs_n[b]` carries the chip-select level only when `req_bank_hit[b]` was 1 in the request. Every other `cs_n` bit stays 1.
- R6: Byte lanes follow `req_port_size`. With 2'b00 (8-bit), only lane `req_addr_lo` is enabled. With 2'b01 (16-bit), lanes 0 and 1 are enabled when `req_addr_lo[1]` is 0, and lanes 2 and 3 when it is 1. With 2'b10 or 2'b11 (32-bit), all four lanes are enabled. Enabled lanes carry the byte-select level and all other lanes stay 1.
- R7: `gpl[i]` equals word bit 23-i for all four phases of the word's cycle.
- R8: A word with bit 0 set is the last one. `busy` falls on the cycle after its T4 phase.
- R9: If the word at index DEPTH-1 has bit 0 clear, the sequence stops after its T4 phase. `err_wrap` is then 1 for exactly the one cycle that follows, while `busy` is 0.
- R10: A request that arrives while `busy` is 1 is ignored. The running sequence keeps its indices, banks and lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ptr_load | input | 1 | Load the write pointer |
| cfg_ptr_val | input | 6 | Value loaded into the write pointer |
| cfg_we | input | 1 | Write one pattern word at the pointer |
| cfg_wdata | input | 32 | Pattern word to write |
| cfg_ptr | output | 6 | Current write pointer |
| req_valid | input | 1 | Access request strobe |
| req_start | input | 6 | First pattern index of the sequence |
| req_bank_hit | input | 8 | Banks that match the access address |
| req_port_size | input | 2 | Port size: 00 8-bit, 01 16-bit, 1x 32-bit |
| req_addr_lo | input | 2 | Two lowest address bits of the access |
| cs_n | output | 8 | Active-low chip selects, one per bank |
| bs_n | output | 4 | Active-low byte selects, one per lane |
| gpl | output | 6 | General-purpose line levels |
| busy | output | 1 | A sequence is running |
| err_wrap | output | 1 | One-cycle pulse when a sequence runs off the top index |

## Verification
The bench builds the block with its default parameters: a 64-word pattern RAM and 8 banks. With these values the bench can write the two top indices and reach the overrun path, where word 63 has no last flag. It can also check that the write pointer steps from 63 back to 0. Using eight banks lets one request route a pattern to the lowest and highest bank at the same time, while a request with an empty hit vector leaves all eight chip selects high. Across the runs, the port-size and address combinations enable a single lane, each lane pair and all four lanes.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_LANE = 4;
    localparam int NUM_GPL  = 6;
    localparam int CS_MSB   = 31;
    localparam int BS_MSB   = 27;
    localparam int GPL_MSB  = 23;
    localparam int LAST_BIT = 0;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        PSZ_8   = 2'b00,
        PSZ_16  = 2'b01,
        PSZ_32  = 2'b10,
        PSZ_32X = 2'b11
    } port_size_e;

    function automatic logic [NUM_LANE-1:0] lane_mask(input logic [1:0] size,
                                                      input logic [1:0] addr);
        logic [NUM_LANE-1:0] m;
        unique case (size)
            PSZ_8:   m = 4'b0001 << addr;
            PSZ_16:  m = addr[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/busseq_pattern_ram.sv
module busseq_pattern_ram
    import busseq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [AW-1:0]     ptr_val,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [AW-1:0]     ptr,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_val;
        end else if (we) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !ptr_load) begin
            mem[ptr_q] <= wdata;
        end
    end

    assign ptr     = ptr_q;
    assign rd_data = mem[rd_addr];

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ptr_load) |=> (ptr_q == $past(ptr_q) + 1'b1));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (ptr_q == $past(ptr_val)));

endmodule

// File: rtl/busseq_sequencer.sv
module busseq_sequencer
    import busseq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int NUM_BANKS = 8,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_start,
    input  logic [NUM_BANKS-1:0] req_hit,
    input  logic [1:0]           req_size,
    input  logic [1:0]           req_addr,
    input  logic                 word_last,
    output logic                 busy,
    output logic [1:0]           phase,
    output logic [AW-1:0]        idx,
    output logic                 err,
    output logic [NUM_BANKS-1:0] hit_q,
    output logic [NUM_LANE-1:0]  lane_q
);

    localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);

    seq_state_e state_q, state_d;
    logic       launch, overrun;
    logic [1:0] phase_q;
    logic [AW-1:0] idx_q;
    logic       err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, finish, overrun
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        overrun = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (req_valid) begin
                    state_d = SEQ_RUN;
                    launch  = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (phase_q == 2'd3) begin
                    if (word_last) begin
                        state_d = SEQ_IDLE;
                    end else if (idx_q == TOP_IDX) begin
                        state_d = SEQ_IDLE;
                        overrun = 1'b1;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // sequencing datapath and captured request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            hit_q   <= '0;
            lane_q  <= '0;
        end else begin
            err_q <= overrun;
            if (launch) begin
                phase_q <= '0;
                idx_q   <= req_start;
                hit_q   <= req_hit;
                lane_q  <= lane_mask(req_size, req_addr);
            end else if (state_q == SEQ_RUN) begin
                phase_q <= phase_q + 1'b1;
                if (phase_q == 2'd3 && !word_last && idx_q != TOP_IDX) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy  = (state_q == SEQ_RUN);
    assign phase = phase_q;
    assign idx   = idx_q;
    assign err   = err_q;

    a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (phase_q == $past(phase_q) + 2'd1));

    a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_q != 2'd0) |-> $stable(idx_q));

    a_r8_end_at_t4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(phase_q) == 2'd3));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (!busy && $past(busy) && $past(idx_q) == TOP_IDX));

    a_r10_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hit_q) && $stable(lane_q)));

endmodule

// File: rtl/busseq_route.sv
module busseq_route
    import busseq_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 busy,
    input  logic [1:0]           phase,
    input  logic [WORD_W-1:0]    word,
    input  logic [NUM_BANKS-1:0] hit_q,
    input  logic [NUM_LANE-1:0]  lane_q,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic [NUM_LANE-1:0]  bs_n,
    output logic [NUM_GPL-1:0]   gpl
);

    logic [3:0] cs_bits, bs_bits;
    logic       cs_lvl, bs_lvl;
    logic       unused_word;

    assign cs_bits     = word[CS_MSB -: 4];
    assign bs_bits     = word[BS_MSB -: 4];
    assign cs_lvl      = cs_bits[2'd3 - phase];
    assign bs_lvl      = bs_bits[2'd3 - phase];
    assign unused_word = ^word[GPL_MSB-NUM_GPL:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign cs_n[b] = (busy && hit_q[b]) ? cs_lvl : 1'b1;
    end

    for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
        assign bs_n[l] = (busy && lane_q[l]) ? bs_lvl : 1'b1;
    end

    for (genvar g = 0; g < NUM_GPL; g++) begin : g_gpl
        assign gpl[g] = busy ? word[GPL_MSB - g] : 1'b0;
    end

endmodule

// File: rtl/busseq_wavegen.sv
module busseq_wavegen
    import busseq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int NUM_BANKS = 8,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_ptr_load,
    input  logic [AW-1:0]        cfg_ptr_val,
    input  logic                 cfg_we,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [AW-1:0]        cfg_ptr,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_start,
    input  logic [NUM_BANKS-1:0] req_bank_hit,
    input  logic [1:0]           req_port_size,
    input  logic [1:0]           req_addr_lo,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic [NUM_LANE-1:0]  bs_n,
    output logic [NUM_GPL-1:0]   gpl,
    output logic                 busy,
    output logic                 err_wrap
);

    logic [WORD_W-1:0]    word;
    logic [AW-1:0]        idx;
    logic [1:0]           phase;
    logic [NUM_BANKS-1:0] hit_q;
    logic [NUM_LANE-1:0]  lane_q;

    busseq_pattern_ram #(.DEPTH(DEPTH)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_load (cfg_ptr_load),
        .ptr_val  (cfg_ptr_val),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .ptr      (cfg_ptr),
        .rd_addr  (idx),
        .rd_data  (word)
    );

    busseq_sequencer #(.DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_start (req_start),
        .req_hit   (req_bank_hit),
        .req_size  (req_port_size),
        .req_addr  (req_addr_lo),
        .word_last (word[LAST_BIT]),
        .busy      (busy),
        .phase     (phase),
        .idx       (idx),
        .err       (err_wrap),
        .hit_q     (hit_q),
        .lane_q    (lane_q)
    );

    busseq_route #(.NUM_BANKS(NUM_BANKS)) u_route (
        .busy   (busy),
        .phase  (phase),
        .word   (word),
        .hit_q  (hit_q),
        .lane_q (lane_q),
        .cs_n   (cs_n),
        .bs_n   (bs_n),
        .gpl    (gpl)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((&cs_n) && (&bs_n) && gpl == '0));

    a_r5_bank_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (((~cs_n) & ~hit_q) == '0));

    a_r6_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (((~bs_n) & ~lane_q) == '0));

endmodule

// File: tb/busseq_wavegen_tb_top.sv
module busseq_wavegen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ptr_load = 1'b0;
    logic [5:0]  cfg_ptr_val = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cfg_ptr;
    logic        req_valid = 1'b0;
    logic [5:0]  req_start = '0;
    logic [7:0]  req_bank_hit = '0;
    logic [1:0]  req_port_size = '0;
    logic [1:0]  req_addr_lo = '0;
    logic [7:0]  cs_n;
    logic [3:0]  bs_n;
    logic [5:0]  gpl;
    logic        busy;
    logic        err_wrap;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [64];
    logic [5:0]  exp_ptr = '0;
    logic [19:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    busseq_wavegen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_ptr_load(cfg_ptr_load), .cfg_ptr_val(cfg_ptr_val),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_ptr(cfg_ptr),
        .req_valid(req_valid), .req_start(req_start),
        .req_bank_hit(req_bank_hit), .req_port_size(req_port_size),
        .req_addr_lo(req_addr_lo),
        .cs_n(cs_n), .bs_n(bs_n), .gpl(gpl), .busy(busy), .err_wrap(err_wrap)
    );

    function automatic logic [31:0] mk(input logic [3:0] cs, input logic [3:0] bs,
                                       input logic [5:0] g, input logic last);
        return {cs, bs, g, 17'd0, last};
    endfunction

    function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] a);
        if (sz == 2'b00) return (a == 2'd0) ? 4'b0001 : (a == 2'd1) ? 4'b0010 :
                                (a == 2'd2) ? 4'b0100 : 4'b1000;
        if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [19:0] expect_cycle(input logic [31:0] w, input int ph,
                                                 input logic [7:0] hit, input logic [3:0] ln);
        logic [7:0] c;
        logic [3:0] b;
        logic [5:0] g;
        for (int i = 0; i < 8; i++) c[i] = hit[i] ? w[31 - ph] : 1'b1;
        for (int i = 0; i < 4; i++) b[i] = ln[i] ? w[27 - ph] : 1'b1;
        for (int i = 0; i < 6; i++) g[i] = w[23 - i];
        return {c, b, g, 1'b1, 1'b0};
    endfunction

    localparam logic [19:0] IDLE_V = {8'hFF, 4'hF, 6'h00, 1'b0, 1'b0};
    localparam logic [19:0] ERR_V  = {8'hFF, 4'hF, 6'h00, 1'b0, 1'b1};

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per clock, sampled 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {cs_n, bs_n, gpl, busy, err_wrap}, e);
        end
    end

    task automatic load_ptr(input logic [5:0] v);
        @(negedge clk);
        cfg_ptr_load = 1'b1;
        cfg_ptr_val  = v;
        @(negedge clk);
        cfg_ptr_load = 1'b0;
        exp_ptr = v;
        check("R2 load", {14'd0, cfg_ptr}, {14'd0, exp_ptr});
    endtask

    task automatic prog_write(input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        model[exp_ptr] = d;
        @(negedge clk);
        cfg_we = 1'b0;
        exp_ptr = exp_ptr + 1'b1;
        check("R2 step", {14'd0, cfg_ptr}, {14'd0, exp_ptr});
    endtask

    // driver: issues a request and pushes the expected per-cycle outputs
    task automatic run_access(input string tag, input logic [5:0] start, input logic [7:0] hit,
                              input logic [1:0] sz, input logic [1:0] a, input bit inject);
        int idx;
        logic [3:0] ln;
        ln = lanes(sz, a);
        @(negedge clk);
        req_valid = 1'b1;
        req_start = start;
        req_bank_hit = hit;
        req_port_size = sz;
        req_addr_lo = a;
        idx = int'(start);
        while (1) begin
            for (int ph = 0; ph < 4; ph++) begin
                exp_q.push_back(expect_cycle(model[idx], ph, hit, ln));
                tag_q.push_back(tag);
            end
            if (model[idx][0]) begin
                exp_q.push_back(IDLE_V);
                tag_q.push_back(tag);
                break;
            end
            if (idx == 63) begin
                exp_q.push_back(ERR_V);
                tag_q.push_back(tag);
                exp_q.push_back(IDLE_V);
                tag_q.push_back(tag);
                break;
            end
            idx++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_start = 6'd10;
            req_bank_hit = 8'hFF;
            req_port_size = 2'b00;
            req_addr_lo = 2'd2;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {cs_n, bs_n, gpl, busy, err_wrap}, IDLE_V);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {cs_n, bs_n, gpl, busy, err_wrap}, IDLE_V);
        check("R2 reset ptr", {14'd0, cfg_ptr}, 20'd0);

        // R2: program sequences through the pointer port
        load_ptr(6'd0);
        prog_write(mk(4'b0011, 4'b0101, 6'b101010, 1'b0));
        prog_write(mk(4'b1100, 4'b0110, 6'b010101, 1'b0));
        prog_write(mk(4'b0000, 4'b1000, 6'b111111, 1'b1));
        load_ptr(6'd10);
        prog_write(mk(4'b1010, 4'b0010, 6'b000001, 1'b1));
        load_ptr(6'd62);
        prog_write(mk(4'b0110, 4'b1001, 6'b100000, 1'b0));
        prog_write(mk(4'b1001, 4'b0100, 6'b000011, 1'b0)); // pointer wraps 63 -> 0

        // R3 R4 R7 R8: three-word sequence, single bank, 32-bit port
        run_access("R3/R4/R7/R8", 6'd0, 8'h04, 2'b10, 2'd0, 1'b0);
        // R3: start index honoured mid-sequence
        run_access("R3 start1", 6'd1, 8'h01, 2'b11, 2'd1, 1'b0);
        // R5 R6: two banks, 8-bit port at each address
        run_access("R5/R6 b8a3", 6'd10, 8'h81, 2'b00, 2'd3, 1'b0);
        run_access("R6 b8a0", 6'd10, 8'h10, 2'b00, 2'd0, 1'b0);
        run_access("R6 b16a2", 6'd10, 8'h02, 2'b01, 2'd2, 1'b0);
        run_access("R6 b16a0", 6'd10, 8'h02, 2'b01, 2'd1, 1'b0);
        // R5: no bank hit keeps all chip selects high
        run_access("R5 nohit", 6'd0, 8'h00, 2'b10, 2'd0, 1'b0);
        // R10: second request during a run is ignored
        run_access("R10 busy req", 6'd0, 8'h20, 2'b01, 2'd2, 1'b1);
        // R9: run off the top index
        run_access("R9 overrun", 6'd62, 8'h08, 2'b10, 2'd0, 1'b0);

        repeat (2) @(negedge clk);
        check("R1 final idle", {cs_n, bs_n, gpl, busy, err_wrap}, IDLE_V);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule